// File: doc/BRIEF.md
# Flash Sector Region Decoder

This block turns a byte offset into a parallel NOR flash array into the erase sector that contains it. The array is split into at most four erase regions that follow one another from offset zero. Each region holds some number of sectors that all share one length, and the regions may use different lengths. Region counts and lengths are fixed by parameters. A lookup returns the sector length, the sector base address, the region index, and a flag for offsets that lie past the end of the array.

The geometry is checked when the block comes out of reset. An illegal geometry raises a configuration error, and the block then refuses all lookups. The parameter for devices per bank sets how byte sizes scale to per-device sizes. Those per-device sizes are used by the alignment rules and by the query-table bytes, which the block serves through a small combinational read port.

A lookup is accepted on a valid/ready handshake. Its result appears, with a valid strobe, in the cycle after the handshake.

Top module: `flash_sector_locator`

## Requirements
- R1: For an accepted offset below the total size, the walk tests the active regions in ascending order. It returns the byte sector length of the first region whose range [start, start + count × length) contains the offset. The regions are placed back to back from offset 0.
- R2: The region index output (2 bits, 0 for the lowest-addressed region) names the region that matched.
- R3: The returned sector base equals the offset rounded down to a multiple of the returned sector length.
- R4: An accepted offset at or beyond the total size returns rspError = 1, with length 0, base 0 and region 0. Any offset below the total size returns rspError = 0.
- R5: rspValid is 1 in exactly those cycles that follow a cycle in which reqValid and reqReady were both 1.
- R6: The active region count is the number of leading regions with a non-zero count. The first zero count ends the list, and every region after it is ignored. Query address 0x2C reads this count.
- R7: Region i of the active list is described at query addresses 0x2D + 4·i through 0x30 + 4·i. The four bytes are, in order: (count − 1)[7:0], (count − 1)[15:8], per-device length[15:8] and per-device length[23:16]. Descriptor bytes of inactive regions read 0, and so do addresses outside 0x2C to 0x3C.
- R8: The per-device length is the byte length divided by the devices per bank. If any active region's per-device length is not a power of two, not a multiple of 256, or not below 2^24, cfgError is 1 and reqReady stays 0.
- R9: If the start of an active region, divided by the devices per bank, is not a multiple of that region's per-device length, cfgError is 1.
- R10: When region 0 has a zero count, a single region is built from the uniform count and length. When both forms are given, the uniform product must equal the regional total, or else cfgError is 1.
- R11: totalSize equals the sum of count × length over the active regions.
- R12: While reset is asserted, rspValid and reqReady are 0. reqReady rises in the first cycle after reset is released when the geometry is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request present |
| reqOffset | input | ADDR_W | Byte offset to locate |
| reqReady | output | 1 | Block accepts a lookup |
| rspValid | output | 1 | Result of the previous cycle's accepted lookup |
| rspSectorLen | output | ADDR_W+1 | Byte length of the containing sector |
| rspSectorBase | output | ADDR_W | Byte address of the sector start |
| rspRegion | output | 2 | Index of the matching region |
| rspError | output | 1 | Offset lies outside the array |
| totalSize | output | ADDR_W+1 | Sum of all active region sizes |
| cfgError | output | 1 | Geometry is illegal |
| qryAddr | input | 8 | Query-table byte address |
| qryData | output | 8 | Query-table byte |

## Verification
The hardest situations to reach from the ports are the illegal geometries and the list cut short by a zero count, because they are fixed at elaboration and cannot be driven at run time. The bench therefore builds several instances side by side, each with its own parameter set: a top-boot map, a bottom-boot map with two devices per bank, a truncated list, a uniform-only map, and four broken maps. The two legal multi-region maps receive the same stream of offsets every cycle. That stream includes the last byte of each region, the first byte of the next one, and offsets past the end.

// File: rtl/flash_sector_pkg.sv
package flash_sector_pkg;
  localparam int unsigned NUM_SLOTS  = 4;
  localparam int unsigned REG_W      = $clog2(NUM_SLOTS);
  localparam int unsigned DESC_BYTES = 4;
  localparam logic [7:0] QRY_COUNT_ADDR = 8'h2C;
  localparam logic [7:0] QRY_DESC_BASE  = 8'h2D;
  localparam logic [7:0] QRY_DESC_END   = QRY_DESC_BASE + 8'(DESC_BYTES * NUM_SLOTS);

  typedef logic [63:0] wide_t;

  typedef struct packed {
    logic capture;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_sector_geom.sv
module flash_sector_geom
  import flash_sector_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DEVS_PER_BANK = 1,
  parameter int unsigned REGION_COUNT [NUM_SLOTS] = '{31, 1, 2, 1},
  parameter int unsigned REGION_LEN [NUM_SLOTS] = '{65536, 32768, 8192, 16384},
  parameter int unsigned UNIFORM_COUNT = 0,
  parameter int unsigned UNIFORM_LEN = 0
) (
  input  logic [7:0]           qryAddr,
  output logic [7:0]           qryData,
  output wide_t                regStart [NUM_SLOTS],
  output wide_t                regSize  [NUM_SLOTS],
  output wide_t                regLen   [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0] regActive,
  output wide_t                totalWide,
  output logic                 cfgError
);
  localparam bit    USE_UNI   = (REGION_COUNT[0] == 0);
  localparam bit    DEV_BAD   = (DEVS_PER_BANK == 0) || ((DEVS_PER_BANK & (DEVS_PER_BANK - 1)) != 0);
  localparam int unsigned DEV_SHIFT = (DEVS_PER_BANK > 1) ? $clog2(DEVS_PER_BANK) : 0;
  localparam wide_t UNI_TOTAL = wide_t'(UNIFORM_COUNT) * wide_t'(UNIFORM_LEN);

  wide_t                effCnt [NUM_SLOTS];
  wide_t                pdLen  [NUM_SLOTS];
  logic [15:0]          cntM1  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] lenBad;
  logic [NUM_SLOTS-1:0] alignBad;
  logic [REG_W:0]       activeCount;
  logic                 mismatch;
  logic                 rangeBad;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_region
    if (i == 0) begin : g_first
      assign effCnt[i]    = USE_UNI ? wide_t'(UNIFORM_COUNT) : wide_t'(REGION_COUNT[i]);
      assign regLen[i]    = USE_UNI ? wide_t'(UNIFORM_LEN) : wide_t'(REGION_LEN[i]);
      assign regActive[i] = (effCnt[i] != '0);
      assign regStart[i]  = '0;
    end else begin : g_rest
      assign effCnt[i]    = USE_UNI ? '0 : wide_t'(REGION_COUNT[i]);
      assign regLen[i]    = wide_t'(REGION_LEN[i]);
      assign regActive[i] = (effCnt[i] != '0) && regActive[i-1];
      assign regStart[i]  = regStart[i-1] + regSize[i-1];
    end
    assign regSize[i] = regActive[i] ? effCnt[i] * regLen[i] : '0;
    assign pdLen[i]   = regLen[i] >> DEV_SHIFT;
    assign cntM1[i]   = 16'(effCnt[i] - 64'd1);
    assign lenBad[i]  = regActive[i] &&
                        ((pdLen[i][7:0] != 8'd0) || (pdLen[i] >= 64'h100_0000) ||
                         (pdLen[i] == '0) || ((pdLen[i] & (pdLen[i] - 64'd1)) != '0));
    assign alignBad[i] = regActive[i] && (((regStart[i] >> DEV_SHIFT) & (pdLen[i] - 64'd1)) != '0);
  end

  assign totalWide   = regStart[NUM_SLOTS-1] + regSize[NUM_SLOTS-1];
  assign activeCount = (REG_W+1)'($countones(regActive));
  assign mismatch    = !USE_UNI && (UNI_TOTAL != '0) && (UNI_TOTAL != totalWide);
  assign rangeBad    = (totalWide == '0) || (totalWide > (64'd1 << ADDR_W));
  assign cfgError    = DEV_BAD || (|lenBad) || (|alignBad) || mismatch || rangeBad;

  always_comb begin
    logic [REG_W-1:0] idx;
    logic [1:0]       sel;
    qryData = '0;
    idx = REG_W'((qryAddr - QRY_DESC_BASE) >> 2);
    sel = 2'(qryAddr - QRY_DESC_BASE);
    if (qryAddr == QRY_COUNT_ADDR) begin
      qryData = 8'(activeCount);
    end else if (qryAddr >= QRY_DESC_BASE && qryAddr < QRY_DESC_END && regActive[idx]) begin
      case (sel)
        2'd0:    qryData = cntM1[idx][7:0];
        2'd1:    qryData = cntM1[idx][15:8];
        2'd2:    qryData = pdLen[idx][15:8];
        default: qryData = pdLen[idx][23:16];
      endcase
    end
  end
endmodule

// File: rtl/flash_sector_ctrl.sv
module flash_sector_ctrl
  import flash_sector_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cfgError,
  output logic       reqReady,
  output logic       rspValid,
  output ctlStrobe_t strobe
);
  logic readyQ;
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      validQ <= 1'b0;
    end else begin
      readyQ <= !cfgError;
      validQ <= strobe.capture;
    end
  end

  assign strobe.capture = reqValid && readyQ;
  assign reqReady = readyQ;
  assign rspValid = validQ;
endmodule

// File: rtl/flash_sector_dp.sv
module flash_sector_dp
  import flash_sector_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    reqOffset,
  input  wide_t                regStart [NUM_SLOTS],
  input  wide_t                regSize  [NUM_SLOTS],
  input  wide_t                regLen   [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] regActive,
  output logic [ADDR_W:0]      sectorLen,
  output logic [ADDR_W-1:0]    sectorBase,
  output logic [REG_W-1:0]     region,
  output logic                 hitError
);
  wide_t                offWide;
  logic [NUM_SLOTS-1:0] hit;
  wide_t                selLen;
  logic [REG_W-1:0]     selIdx;
  logic                 found;
  logic [ADDR_W-1:0]    lowMask;

  assign offWide = wide_t'(reqOffset);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
    assign hit[i] = regActive[i] && (offWide >= regStart[i]) &&
                    (offWide < regStart[i] + regSize[i]);
  end

  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    selLen = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found  = 1'b1;
        selIdx = REG_W'(i);
        selLen = regLen[i];
      end
    end
  end

  assign lowMask = ADDR_W'(selLen - 64'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectorLen  <= '0;
      sectorBase <= '0;
      region     <= '0;
      hitError   <= 1'b0;
    end else if (strobe.capture) begin
      sectorLen  <= found ? (ADDR_W+1)'(selLen) : '0;
      sectorBase <= found ? (reqOffset & ~lowMask) : '0;
      region     <= found ? selIdx : '0;
      hitError   <= !found;
    end
  end
endmodule

// File: rtl/flash_sector_locator.sv
module flash_sector_locator
  import flash_sector_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DEVS_PER_BANK = 1,
  parameter int unsigned REGION_COUNT [NUM_SLOTS] = '{31, 1, 2, 1},
  parameter int unsigned REGION_LEN [NUM_SLOTS] = '{65536, 32768, 8192, 16384},
  parameter int unsigned UNIFORM_COUNT = 0,
  parameter int unsigned UNIFORM_LEN = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqOffset,
  output logic              reqReady,
  output logic              rspValid,
  output logic [ADDR_W:0]   rspSectorLen,
  output logic [ADDR_W-1:0] rspSectorBase,
  output logic [1:0]        rspRegion,
  output logic              rspError,
  output logic [ADDR_W:0]   totalSize,
  output logic              cfgError,
  input  logic [7:0]        qryAddr,
  output logic [7:0]        qryData
);
  wide_t                regStart [NUM_SLOTS];
  wide_t                regSize  [NUM_SLOTS];
  wide_t                regLen   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] regActive;
  wide_t                totalWide;
  ctlStrobe_t           strobe;

  flash_sector_geom #(
    .ADDR_W(ADDR_W), .DEVS_PER_BANK(DEVS_PER_BANK),
    .REGION_COUNT(REGION_COUNT), .REGION_LEN(REGION_LEN),
    .UNIFORM_COUNT(UNIFORM_COUNT), .UNIFORM_LEN(UNIFORM_LEN)
  ) u_geom (
    .qryAddr(qryAddr), .qryData(qryData),
    .regStart(regStart), .regSize(regSize), .regLen(regLen),
    .regActive(regActive), .totalWide(totalWide), .cfgError(cfgError)
  );

  flash_sector_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgError(cfgError),
    .reqReady(reqReady), .rspValid(rspValid), .strobe(strobe)
  );

  flash_sector_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOffset(reqOffset),
    .regStart(regStart), .regSize(regSize), .regLen(regLen), .regActive(regActive),
    .sectorLen(rspSectorLen), .sectorBase(rspSectorBase), .region(rspRegion),
    .hitError(rspError)
  );

  assign totalSize = (ADDR_W+1)'(totalWide);
endmodule

// File: rtl/flash_sector_locator_chk.sv
module flash_sector_locator_chk #(
  parameter int unsigned ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqOffset,
  input logic              rspValid,
  input logic [ADDR_W:0]   rspSectorLen,
  input logic [ADDR_W-1:0] rspSectorBase,
  input logic              rspError,
  input logic [ADDR_W:0]   totalSize,
  input logic              cfgError
);
  logic accept;
  assign accept = reqValid && reqReady;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);  // R5
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);  // R5
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspError) |-> ((rspSectorBase & ADDR_W'(rspSectorLen - 1'b1)) == '0));  // R3
  AST_SECTOR_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspError) |->
      ((ADDR_W+2)'(rspSectorBase) + (ADDR_W+2)'(rspSectorLen) <= (ADDR_W+2)'(totalSize)));  // R1
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && ((ADDR_W+1)'(reqOffset) >= totalSize)) |=> rspError);  // R4
  AST_IN_RANGE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (accept && ((ADDR_W+1)'(reqOffset) < totalSize)) |=> (!rspError && rspSectorLen != '0));  // R1
  AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !reqReady);  // R8
endmodule

bind flash_sector_locator flash_sector_locator_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqOffset(reqOffset), .rspValid(rspValid), .rspSectorLen(rspSectorLen),
  .rspSectorBase(rspSectorBase), .rspError(rspError), .totalSize(totalSize),
  .cfgError(cfgError)
);

// File: tb/flash_sector_locator_bench.sv
module flash_sector_locator_bench;
  localparam int CLK_PERIOD = 10;
  typedef longint geo_t [4];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic        reqValid = 1'b0;
  logic [21:0] reqOffset = '0;
  logic [7:0]  qryAddr = '0;
  logic        badValid = 1'b0;

  // Legal multi-region instances A (top boot, x1) and B (bottom boot, x2)
  logic rdyA, rvA, errA, cfgA, rdyB, rvB, errB, cfgB;
  logic [22:0] lenA, totA, lenB, totB;
  logic [21:0] baseA, baseB;
  logic [1:0]  regA, regB;
  logic [7:0]  qdA, qdB;

  // Single-region and illegal instances
  logic rdyC, rvC, erC, cfgC; logic [16:0] lnC, toC; logic [15:0] bsC; logic [1:0] rgC; logic [7:0] qdC;
  logic rdyD, rvD, erD, cfgD; logic [17:0] lnD, toD; logic [16:0] bsD; logic [1:0] rgD; logic [7:0] qdD;
  logic rdyE, rvE, erE, cfgE; logic [16:0] lnE, toE; logic [15:0] bsE; logic [1:0] rgE; logic [7:0] qdE;
  logic rdyF, rvF, erF, cfgF; logic [16:0] lnF, toF; logic [15:0] bsF; logic [1:0] rgF; logic [7:0] qdF;
  logic rdyG, rvG, erG, cfgG; logic [16:0] lnG, toG; logic [15:0] bsG; logic [1:0] rgG; logic [7:0] qdG;
  logic rdyH, rvH, erH, cfgH; logic [16:0] lnH, toH; logic [15:0] bsH; logic [1:0] rgH; logic [7:0] qdH;

  geo_t cntA = '{31, 1, 2, 1};
  geo_t lnGA = '{65536, 32768, 8192, 16384};
  geo_t cntB = '{1, 2, 1, 31};
  geo_t lnGB = '{16384, 8192, 32768, 65536};

  flash_sector_locator u_flash_sector_locator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset), .reqReady(rdyA),
    .rspValid(rvA), .rspSectorLen(lenA), .rspSectorBase(baseA), .rspRegion(regA),
    .rspError(errA), .totalSize(totA), .cfgError(cfgA), .qryAddr(qryAddr), .qryData(qdA));

  flash_sector_locator #(.ADDR_W(22), .DEVS_PER_BANK(2),
    .REGION_COUNT('{1, 2, 1, 31}), .REGION_LEN('{16384, 8192, 32768, 65536})) u_bottom (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset), .reqReady(rdyB),
    .rspValid(rvB), .rspSectorLen(lenB), .rspSectorBase(baseB), .rspRegion(regB),
    .rspError(errB), .totalSize(totB), .cfgError(cfgB), .qryAddr(qryAddr), .qryData(qdB));

  flash_sector_locator #(.ADDR_W(16), .REGION_COUNT('{3, 0, 5, 0}),
    .REGION_LEN('{4096, 4096, 4096, 4096}), .UNIFORM_COUNT(3), .UNIFORM_LEN(4096)) u_trunc (
    .clk(clk), .rstN(rstN), .reqValid(1'b0), .reqOffset(16'd0), .reqReady(rdyC),
    .rspValid(rvC), .rspSectorLen(lnC), .rspSectorBase(bsC), .rspRegion(rgC),
    .rspError(erC), .totalSize(toC), .cfgError(cfgC), .qryAddr(qryAddr), .qryData(qdC));

  flash_sector_locator #(.ADDR_W(17), .REGION_COUNT('{0, 0, 0, 0}),
    .REGION_LEN('{0, 0, 0, 0}), .UNIFORM_COUNT(16), .UNIFORM_LEN(4096)) u_uni (
    .clk(clk), .rstN(rstN), .reqValid(1'b0), .reqOffset(17'd0), .reqReady(rdyD),
    .rspValid(rvD), .rspSectorLen(lnD), .rspSectorBase(bsD), .rspRegion(rgD),
    .rspError(erD), .totalSize(toD), .cfgError(cfgD), .qryAddr(qryAddr), .qryData(qdD));

  flash_sector_locator #(.ADDR_W(16), .REGION_COUNT('{4, 0, 0, 0}),
    .REGION_LEN('{128, 0, 0, 0})) u_shortLen (
    .clk(clk), .rstN(rstN), .reqValid(badValid), .reqOffset(16'd0), .reqReady(rdyE),
    .rspValid(rvE), .rspSectorLen(lnE), .rspSectorBase(bsE), .rspRegion(rgE),
    .rspError(erE), .totalSize(toE), .cfgError(cfgE), .qryAddr(qryAddr), .qryData(qdE));

  flash_sector_locator #(.ADDR_W(16), .REGION_COUNT('{1, 3, 0, 0}),
    .REGION_LEN('{8192, 16384, 0, 0})) u_misalign (
    .clk(clk), .rstN(rstN), .reqValid(badValid), .reqOffset(16'd0), .reqReady(rdyF),
    .rspValid(rvF), .rspSectorLen(lnF), .rspSectorBase(bsF), .rspRegion(rgF),
    .rspError(erF), .totalSize(toF), .cfgError(cfgF), .qryAddr(qryAddr), .qryData(qdF));

  flash_sector_locator #(.ADDR_W(16), .REGION_COUNT('{4, 0, 0, 0}),
    .REGION_LEN('{4096, 0, 0, 0}), .UNIFORM_COUNT(2), .UNIFORM_LEN(4096)) u_mismatch (
    .clk(clk), .rstN(rstN), .reqValid(badValid), .reqOffset(16'd0), .reqReady(rdyG),
    .rspValid(rvG), .rspSectorLen(lnG), .rspSectorBase(bsG), .rspRegion(rgG),
    .rspError(erG), .totalSize(toG), .cfgError(cfgG), .qryAddr(qryAddr), .qryData(qdG));

  flash_sector_locator #(.ADDR_W(16), .DEVS_PER_BANK(2), .REGION_COUNT('{8, 0, 0, 0}),
    .REGION_LEN('{256, 0, 0, 0})) u_devScale (
    .clk(clk), .rstN(rstN), .reqValid(badValid), .reqOffset(16'd0), .reqReady(rdyH),
    .rspValid(rvH), .rspSectorLen(lnH), .rspSectorBase(bsH), .rspRegion(rgH),
    .rspError(erH), .totalSize(toH), .cfgError(cfgH), .qryAddr(qryAddr), .qryData(qdH));

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void refLookup(input geo_t cnt, input geo_t len, input longint off,
                                    output longint eLen, output longint eBase,
                                    output longint eReg, output longint eErr);
    longint start = 0;
    eLen = 0; eBase = 0; eReg = 0; eErr = 1;
    for (int i = 0; i < 4; i++) begin
      if (cnt[i] == 0) break;
      if (off >= start && off < start + cnt[i] * len[i]) begin
        eLen = len[i]; eBase = off - (off % len[i]); eReg = i; eErr = 0;
        break;
      end
      start += cnt[i] * len[i];
    end
  endfunction

  function automatic longint refQuery(input geo_t cnt, input geo_t len, input longint devs,
                                      input longint addr);
    longint n = 0;
    longint i, b, cm1, pd;
    for (int k = 0; k < 4; k++) begin
      if (cnt[k] == 0) break;
      n++;
    end
    if (addr == 'h2C) return n;
    if (addr < 'h2D || addr > 'h3C) return 0;
    i = (addr - 'h2D) / 4;
    b = (addr - 'h2D) % 4;
    if (i >= n) return 0;
    cm1 = cnt[i] - 1;
    pd = len[i] / devs;
    case (b)
      0: return cm1 % 256;
      1: return (cm1 / 256) % 256;
      2: return (pd / 256) % 256;
      default: return (pd / 65536) % 256;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    longint dir [12] = '{0, 65535, 65536, 2031615, 2031616, 2064383, 2064384,
                         2072576, 2080768, 2097151, 2097152, 4194303};
    bit pendA = 0, pendB = 0;
    longint eLenA, eBaseA, eRegA, eErrA, eLenB, eBaseB, eRegB, eErrB;
    longint seed = 32'h1234_5678;
    longint off;

    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 rspValid in reset", rvA, 0);
    chk("R12 reqReady in reset", rdyA, 0);
    chk("R12 reqReady in reset (B)", rdyB, 0);
    rstN = 1'b1;
    badValid = 1'b1;
    @(negedge clk);
    chk("R12 reqReady after reset", rdyA, 1);
    chk("R11 total size A", totA, 2097152);
    chk("R11 total size B", totB, 2097152);
    chk("R8 legal geometry A", cfgA, 0);
    chk("R9 legal bottom-boot alignment B", cfgB, 0);

    for (int cyc = 0; cyc < 600; cyc++) begin
      bit nv;
      // compare the result of the handshake driven on the previous negedge
      chk("R5 rspValid A", rvA, pendA);
      chk("R5 rspValid B", rvB, pendB);
      if (pendA) begin
        chk("R1 sector length A", lenA, eLenA);
        chk("R3 sector base A", baseA, eBaseA);
        chk("R2 region A", regA, eRegA);
        chk("R4 error A", errA, eErrA);
      end
      if (pendB) begin
        chk("R1 sector length B", lenB, eLenB);
        chk("R3 sector base B", baseB, eBaseB);
        chk("R2 region B", regB, eRegB);
        chk("R4 error B", errB, eErrB);
      end
      nv = (cyc % 5) != 3;
      if (cyc < 60) off = dir[cyc % 12];
      else begin
        seed = (seed * 1103515245 + 12345) & 64'hFFFF_FFFF;
        off = (seed >> 5) % 2359296;
      end
      reqValid = nv;
      reqOffset = 22'(off);
      pendA = nv && rdyA;
      pendB = nv && rdyB;
      refLookup(cntA, lnGA, off, eLenA, eBaseA, eRegA, eErrA);
      refLookup(cntB, lnGB, off, eLenB, eBaseB, eRegB, eErrB);
      @(negedge clk);
    end
    chk("R5 rspValid A final", rvA, pendA);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R5 rspValid idle A", rvA, 0);

    // R6 / R7 query table for the two multi-region maps
    for (int a = 'h2A; a <= 'h3E; a++) begin
      qryAddr = 8'(a);
      #1;
      chk($sformatf("R7 query A addr %0h", a), qdA, refQuery(cntA, lnGA, 1, a));
      chk($sformatf("R7 query B addr %0h", a), qdB, refQuery(cntB, lnGB, 2, a));
    end
    qryAddr = 8'h2C;
    #1;
    chk("R6 region count A", qdA, 4);
    chk("R6 truncated list count C", qdC, 1);
    chk("R10 uniform fallback count D", qdD, 1);
    qryAddr = 8'h31;
    #1;
    chk("R6 region after zero count ignored C", qdC, 0);
    qryAddr = 8'h2D;
    #1;
    chk("R10 uniform count-1 D", qdD, 15);
    qryAddr = 8'h2F;
    #1;
    chk("R10 uniform length byte D", qdD, 16);
    chk("R6 truncated total C", toC, 12288);
    chk("R6 truncated map legal C", cfgC, 0);
    chk("R10 uniform total D", toD, 65536);
    chk("R10 uniform map legal D", cfgD, 0);
    chk("R11 uniform ready D", rdyD, 1);

    // R8 / R9 / R10 illegal geometries
    chk("R8 per-device length below 256 E", cfgE, 1);
    chk("R8 ready held low E", rdyE, 0);
    chk("R8 no response E", rvE, 0);
    chk("R8 device scaling makes length illegal H", cfgH, 1);
    chk("R8 ready held low H", rdyH, 0);
    chk("R9 misaligned region F", cfgF, 1);
    chk("R9 ready held low F", rdyF, 0);
    chk("R9 no response F", rvF, 0);
    chk("R10 uniform/regional size mismatch G", cfgG, 1);
    chk("R10 ready held low G", rdyG, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule